// File: doc/BRIEF.md
# Boot Mode Register with Bus-Width Hand-Over

This block holds the operating mode a chip boots into. While reset is held it samples three strapping pins. From them it derives three things: where the reset vector is fetched from, the starting bus mode, and the data-bus width used for chip-select area 0. It also raises a flag when the strapping code is one this part cannot honour.

Software then writes a single 8-bit mode register at byte address 0x000007FF. Only the first legal write after reset takes effect. It fixes the bus mode. From that same clock edge on, it also hands control of the area 0 width from the strapping pins to the width field of area 0's configuration register. That field resets to 8 bits. Software must therefore program it before the mode write, or area 0 falls to an 8-bit bus. Later writes, and writes with a reserved encoding, are refused and leave sticky error flags.

Top module: `boot_mode_ctl`

## Requirements
- R1: On the last clock edge with `rst` high, the pin code is decoded into outputs as follows (mode: 00 single-chip, 01 internal ROM with external bus, 10 external ROM with external bus; width: 00 8-bit, 01 16-bit, 10 32-bit):
  - code 000 gives mode 10, width 00 and an external vector.
  - code 001 gives mode 10, width 01 and an external vector.
  - code 010 gives mode 10 and width 10, and raises `pin_err` because a 32-bit bus is unsupported.
  - code 011 gives mode 00, width 00 and an internal vector (`vec_internal`=1).
  - Any code with bit 2 set gives mode 10, width 00 and an external vector, and raises `pin_err`.
- R2: Changes on `mode_pins` after reset is released have no effect on any output.
- R3: While the register is unlocked, `bus_width` keeps the pin-derived width whatever `area0_width` does.
- R4: A legal write locks the register at the next edge and copies `wr_data[7:6]` to `bus_mode`. A legal write has `wr_en`=1, `wr_addr`=0x7FF, `wr_data[7:6]`≠11 and `wr_data[5:0]`=0.
- R5: From the edge that locks the register, `bus_width` equals the `area0_width` value sampled at the previous clock edge.
- R6: A write to any other address changes nothing.
- R7: A write to 0x7FF with `wr_data[7:6]`=11 or a nonzero `wr_data[5:0]` sets sticky `illegal_err`. It leaves `bus_mode` unchanged and the register unlocked.
- R8: Once locked, any write to 0x7FF is ignored and sets sticky `rewrite_err`. `bus_mode` and the lock hold until reset.
- R9: Reset clears the lock and both write-error flags, and samples the pins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pins | input | 3 | Boot strapping pins |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 32 | Byte write address |
| wr_data | input | 8 | Byte write data |
| area0_width | input | 2 | Width field of area 0's configuration register |
| bus_mode | output | 2 | Effective bus mode |
| bus_width | output | 2 | Effective area 0 bus width |
| vec_internal | output | 1 | Reset vector taken from internal memory |
| pin_err | output | 1 | Strapping code not supported |
| mode_locked | output | 1 | Mode register has been written |
| illegal_err | output | 1 | Sticky: reserved encoding written |
| rewrite_err | output | 1 | Sticky: write after lock |

## Verification
The bench targets three kinds of mistake.

- **Pin decode.** It strobes every strapping code through reset. A decoder that mixed up the 16-bit and 32-bit codes, or that accepted a code with bit 2 set, would show the wrong width or a missing `pin_err`.
- **Width hand-over.** It moves `area0_width` both before and after the lock. A design that switched source one cycle late, or switched on an illegal write, would show the pin width where the configured width belongs, or the reverse.
- **Lock and errors.** It wiggles the pins after release, sends a reserved encoding before the legal write and a second write after it, then resets. A design that let the pins through, burned its only write on a rejected value, or kept the lock across reset would diverge from the reference model.

// File: rtl/bootmode_pkg.sv
package bootmode_pkg;

  typedef enum logic [1:0] {
    BM_SINGLE     = 2'b00,
    BM_INTROM_EXT = 2'b01,
    BM_EXTROM_EXT = 2'b10,
    BM_RSVD       = 2'b11
  } bus_mode_e;

  typedef enum logic [1:0] {
    BW_8    = 2'b00,
    BW_16   = 2'b01,
    BW_32   = 2'b10,
    BW_RSVD = 2'b11
  } bus_width_e;

  typedef struct packed {
    bus_mode_e  mode;
    bus_width_e width;
    logic       vec_internal;
    logic       pin_bad;
  } pin_cfg_t;

endpackage

// File: rtl/bm_pin_decode.sv
module bm_pin_decode
  import bootmode_pkg::*;
#(
  parameter int PIN_W = 3
) (
  input  logic [PIN_W-1:0] code,
  output pin_cfg_t         cfg
);
  localparam int HI = PIN_W - 1;

  logic upper_set;

  generate
    if (PIN_W > 2) begin : g_upper
      assign upper_set = |code[HI:2];
    end else begin : g_no_upper
      assign upper_set = 1'b0;
    end
  endgenerate

  always_comb begin
    cfg.mode         = BM_EXTROM_EXT;
    cfg.width        = BW_8;
    cfg.vec_internal = 1'b0;
    cfg.pin_bad      = 1'b0;
    if (upper_set) begin
      cfg.pin_bad = 1'b1;
    end else begin
      unique case (code[1:0])
        2'b00: cfg.width = BW_8;
        2'b01: cfg.width = BW_16;
        2'b10: begin
          cfg.width   = BW_32;
          cfg.pin_bad = 1'b1;
        end
        default: begin
          cfg.mode         = BM_SINGLE;
          cfg.vec_internal = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/bm_once_reg.sv
module bm_once_reg
  import bootmode_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 8,
  parameter int          MODE_W    = 2,
  parameter logic [31:0] MODE_ADDR = 32'h0000_07FF
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_mode_e         init_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output bus_mode_e         mode_q,
  output logic              locked_q,
  output logic              lock_now,
  output logic              illegal_q,
  output logic              rewrite_q
);
  localparam int RSV_W = DATA_W - MODE_W;
  localparam logic [ADDR_W-1:0] HIT_ADDR = MODE_ADDR[ADDR_W-1:0];

  logic              hit;
  logic [MODE_W-1:0] fld_mode;
  logic [RSV_W-1:0]  fld_rsv;
  logic              bad_enc;

  assign hit      = wr_en && (wr_addr == HIT_ADDR);
  assign fld_mode = wr_data[DATA_W-1 -: MODE_W];
  assign fld_rsv  = wr_data[RSV_W-1:0];
  assign bad_enc  = (&fld_mode) || (|fld_rsv);
  assign lock_now = hit && !locked_q && !bad_enc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= init_mode;
      locked_q  <= 1'b0;
      illegal_q <= 1'b0;
      rewrite_q <= 1'b0;
    end else if (hit) begin
      if (locked_q) begin
        rewrite_q <= 1'b1;
      end else if (bad_enc) begin
        illegal_q <= 1'b1;
      end else begin
        mode_q   <= bus_mode_e'(fld_mode);
        locked_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bm_width_sel.sv
module bm_width_sel
  import bootmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_width_e init_width,
  input  bus_width_e pin_width,
  input  bus_width_e cfg_width,
  input  logic       use_cfg,
  output bus_width_e width_q
);
  always_ff @(posedge clk) begin
    if (rst)          width_q <= init_width;
    else if (use_cfg) width_q <= cfg_width;
    else              width_q <= pin_width;
  end
endmodule

// File: rtl/boot_mode_ctl.sv
module boot_mode_ctl
  import bootmode_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 8,
  parameter int          PIN_W     = 3,
  parameter logic [31:0] MODE_ADDR = 32'h0000_07FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  mode_pins,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        area0_width,
  output logic [1:0]        bus_mode,
  output logic [1:0]        bus_width,
  output logic              vec_internal,
  output logic              pin_err,
  output logic              mode_locked,
  output logic              illegal_err,
  output logic              rewrite_err
);
  localparam int MODE_W = 2;

  logic [PIN_W-1:0] pin_q;
  logic [PIN_W-1:0] dec_in;
  pin_cfg_t         dec;
  bus_mode_e        mode_q;
  bus_width_e       width_q;
  logic             locked_q, lock_now;
  logic             vec_q, perr_q;

  // The strap register follows the pins only while reset is held,
  // so the last reset edge leaves the code that applies from then on.
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= mode_pins;
      vec_q  <= dec.vec_internal;
      perr_q <= dec.pin_bad;
    end
  end

  assign dec_in = rst ? mode_pins : pin_q;

  bm_pin_decode #(.PIN_W(PIN_W)) u_dec (
    .code (dec_in),
    .cfg  (dec)
  );

  bm_once_reg #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MODE_W    (MODE_W),
    .MODE_ADDR (MODE_ADDR)
  ) u_once (
    .clk       (clk),
    .rst       (rst),
    .init_mode (dec.mode),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode_q    (mode_q),
    .locked_q  (locked_q),
    .lock_now  (lock_now),
    .illegal_q (illegal_err),
    .rewrite_q (rewrite_err)
  );

  bm_width_sel u_wsel (
    .clk        (clk),
    .rst        (rst),
    .init_width (dec.width),
    .pin_width  (dec.width),
    .cfg_width  (bus_width_e'(area0_width)),
    .use_cfg    (locked_q || lock_now),
    .width_q    (width_q)
  );

  assign bus_mode     = mode_q;
  assign bus_width    = width_q;
  assign vec_internal = vec_q;
  assign pin_err      = perr_q;
  assign mode_locked  = locked_q;

endmodule

// File: rtl/boot_mode_ctl_chk.sv
module boot_mode_ctl_chk #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 8,
  parameter int          PIN_W     = 3,
  parameter logic [31:0] MODE_ADDR = 32'h0000_07FF
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        area0_width,
  input logic [1:0]        bus_mode,
  input logic [1:0]        bus_width,
  input logic              vec_internal,
  input logic              pin_err,
  input logic              mode_locked,
  input logic              illegal_err,
  input logic              rewrite_err
);
  logic hit, legal;
  assign hit   = wr_en && (wr_addr == MODE_ADDR[ADDR_W-1:0]);
  assign legal = (wr_data[DATA_W-1 -: 2] != 2'b11) && (wr_data[DATA_W-3:0] == '0);

  p_strap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(vec_internal) && $stable(pin_err)));

  p_pin_width_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_locked && !(hit && legal)) |=> $stable(bus_width));

  p_good_write_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && legal && !mode_locked) |=> (mode_locked && bus_mode == $past(wr_data[DATA_W-1 -: 2])));

  p_cfg_width_r5: assert property (@(posedge clk) disable iff (rst)
    mode_locked |=> (bus_width == $past(area0_width)));

  p_bad_write_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && !legal && !mode_locked) |=> (illegal_err && !mode_locked && $stable(bus_mode)));

  p_illegal_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    illegal_err |=> illegal_err);

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mode_locked |=> (mode_locked && $stable(bus_mode)));

  p_rewrite_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && mode_locked) |=> rewrite_err);

  p_rewrite_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    rewrite_err |=> rewrite_err);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!mode_locked && !illegal_err && !rewrite_err));

endmodule

bind boot_mode_ctl boot_mode_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W), .MODE_ADDR(MODE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .area0_width(area0_width), .bus_mode(bus_mode), .bus_width(bus_width),
  .vec_internal(vec_internal), .pin_err(pin_err), .mode_locked(mode_locked),
  .illegal_err(illegal_err), .rewrite_err(rewrite_err)
);

// File: tb/tb_boot_mode_ctl.sv
module tb_boot_mode_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_pins = 3'b000;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = 32'h0;
  logic [7:0]  wr_data = 8'h0;
  logic [1:0]  area0_width = 2'b00;
  logic [1:0]  bus_mode, bus_width;
  logic        vec_internal, pin_err, mode_locked, illegal_err, rewrite_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  boot_mode_ctl dut (
    .clk(clk), .rst(rst), .mode_pins(mode_pins), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .area0_width(area0_width),
    .bus_mode(bus_mode), .bus_width(bus_width), .vec_internal(vec_internal),
    .pin_err(pin_err), .mode_locked(mode_locked), .illegal_err(illegal_err),
    .rewrite_err(rewrite_err)
  );

  // Behavioural reference model
  int  m_pins, m_mode, m_width, m_vec, m_perr, m_lock, m_ill, m_rew;
  bit  m_valid = 0;

  function automatic void strap(input int c, output int md, output int w,
                                output int v, output int e);
    md = 2; w = 0; v = 0; e = 0;
    if (c >= 4) e = 1;
    else if (c == 1) w = 1;
    else if (c == 2) begin w = 2; e = 1; end
    else if (c == 3) begin md = 0; v = 1; end
  endfunction

  always @(posedge clk) begin
    int d_md, d_w, d_v, d_e;
    bit hit, ok;
    if (rst) begin
      m_pins = int'(mode_pins);
      strap(m_pins, d_md, d_w, d_v, d_e);
      m_mode = d_md; m_width = d_w; m_vec = d_v; m_perr = d_e;
      m_lock = 0; m_ill = 0; m_rew = 0;
      m_valid = 1;
    end else begin
      strap(m_pins, d_md, d_w, d_v, d_e);
      hit = wr_en && (wr_addr == 32'h7FF);
      ok  = 0;
      if (hit) begin
        if (m_lock != 0) m_rew = 1;
        else if (wr_data[7:6] == 2'b11 || wr_data[5:0] != 6'd0) m_ill = 1;
        else begin ok = 1; m_mode = int'(wr_data[7:6]); end
      end
      if (m_lock != 0 || ok) m_width = int'(area0_width);
      else m_width = d_w;
      if (ok) m_lock = 1;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !done) begin
      check("R4 model bus_mode", bus_mode, m_mode);
      check(m_lock != 0 ? "R5 model bus_width" : "R3 model bus_width", bus_width, m_width);
      check("R1 model vec_internal", vec_internal, m_vec);
      check("R1 model pin_err", pin_err, m_perr);
      check("R8 model lock", mode_locked, m_lock);
      check("R7 model illegal_err", illegal_err, m_ill);
      check("R8 model rewrite_err", rewrite_err, m_rew);
    end
  end

  task automatic do_reset(input logic [2:0] pins);
    @(negedge clk);
    rst = 1'b1; mode_pins = pins;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    // R1 / R9: every strap code through reset
    for (int c = 0; c < 8; c++) begin
      int md, w, v, e;
      do_reset(3'(c));
      strap(c, md, w, v, e);
      check("R1 strap mode", bus_mode, md);
      check("R1 strap width", bus_width, w);
      check("R1 strap vector", vec_internal, v);
      check("R1 strap pin_err", pin_err, e);
    end

    do_reset(3'b001);
    check("R9 lock clear", mode_locked, 0);
    // R2, R3: pins and area width move, outputs hold
    @(negedge clk); mode_pins = 3'b011; area0_width = 2'b10;
    repeat (3) @(negedge clk);
    check("R2 pins ignored mode", bus_mode, 2);
    check("R2 pins ignored vector", vec_internal, 0);
    check("R3 width from pins", bus_width, 1);

    // R6: other address
    wr(32'h7FE, 8'h40);
    check("R6 other addr lock", mode_locked, 0);
    check("R6 other addr mode", bus_mode, 2);

    // R7: reserved encodings
    wr(32'h7FF, 8'hC0);
    check("R7 illegal flag", illegal_err, 1);
    check("R7 not locked", mode_locked, 0);
    wr(32'h7FF, 8'h41);
    check("R7 mode kept", bus_mode, 2);
    check("R7 width kept", bus_width, 1);

    // R4, R5: legal write hands width to area config
    wr(32'h7FF, 8'h40);
    check("R4 locked", mode_locked, 1);
    check("R4 mode", bus_mode, 1);
    check("R5 width from cfg", bus_width, 2);
    @(negedge clk); area0_width = 2'b00;
    @(negedge clk);
    check("R5 width follows cfg", bus_width, 0);

    // R8: rewrite refused
    wr(32'h7FF, 8'h00);
    check("R8 rewrite flag", rewrite_err, 1);
    check("R8 mode held", bus_mode, 1);

    // R9: reset clears, then new pins and a fresh write
    do_reset(3'b011);
    check("R9 lock", mode_locked, 0);
    check("R9 illegal", illegal_err, 0);
    check("R9 rewrite", rewrite_err, 0);
    check("R9 resampled vector", vec_internal, 1);
    area0_width = 2'b01;
    wr(32'h7FF, 8'h80);
    check("R4 mode after reset", bus_mode, 2);
    check("R5 width after reset", bus_width, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule